// File: doc/BRIEF.md
# Partitioned Victim-Way Selector for a Shared Cache

This block chooses which way of a set-associative shared cache receives a new line on a miss, while keeping the cache's capacity split between requester classes. Every class owns a way mask that lists the ways it may fill. Lookups are not restricted. A hit in any way is accepted and refreshes that way's recency, even when the way lies outside the requester's mask. As a result, lines that an earlier partition placed stay reachable until they age out.

The cache pipeline presents the indexed set's per-way valid bits and age counters, together with the requester class and the hit result. In the same cycle the block returns the victim way on a miss, the touched way, and the rewritten age vector for the recency array. Masks are loaded through a single write port, which lets software grow one class's share and then shrink it step by step at run time. A mask change applies from the next lookup onward and never disturbs stored lines. A write of an all-zero mask is refused, so every class always has at least one way it can fill.

Top module: `wpr_victim_sel`

## Requirements
- R1: After reset, the mask of every class is all ones. Any class that misses can then fill any of the 12 ways.
- R2: A write with a nonzero `cfg_mask` replaces the mask of class `cfg_cls` at the clock edge. A lookup in the same cycle as the write still uses the old mask. Lookups from the next cycle onward use the new mask.
- R3: A write of an all-zero mask is ignored, and the class keeps its previous mask.
- R4: On a miss (`lkp_valid`=1, `lkp_hit`=0), `vic_valid` is 1 and `vic_way` is a way whose bit is set in the requester's mask. Bit i of a mask stands for way i. This also holds with disjoint masks such as 0xF80 for one class and 0x07F for another.
- R5: On a miss, if any allowed way has `set_valid` low, the victim is the lowest-numbered such way.
- R6: On a miss where every allowed way is valid, the victim is the allowed way with the largest age (the age of way i is `set_age[4i+3:4i]`). Among equal ages, the lowest index wins.
- R7: On a hit, `upd_valid`=1, `upd_way`=`lkp_hit_way` and `vic_valid`=0, whether or not the hit way is in the mask.
- R8: On any lookup, the touched way's age in `age_next` becomes 0. Every other way whose age is below a reference age gains one, and every remaining way keeps its age. The reference age is the touched way's input age, except on a fill of an invalid way, where it is 11.
- R9: With `lkp_valid`=0, `upd_valid` and `vic_valid` are 0 and `age_next` equals `set_age`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_cls | input | 2 | Class whose mask is written |
| cfg_mask | input | 12 | New mask value |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_cls | input | 2 | Requester class of the lookup |
| lkp_hit | input | 1 | The lookup hit |
| lkp_hit_way | input | 4 | Way that hit |
| set_valid | input | 12 | Valid bit of each way in the indexed set |
| set_age | input | 48 | 4-bit age per way, way 0 in the low bits |
| upd_valid | output | 1 | Recency update is active |
| upd_way | output | 4 | Way touched by this lookup |
| vic_valid | output | 1 | A victim is chosen (miss) |
| vic_way | output | 4 | Chosen victim way |
| age_next | output | 48 | Age vector to write back for the set |

## Verification
A mask write and a miss from the same class can arrive in the same cycle. The miss must then be served with the old mask, and the new mask must apply only from the following lookup. The bench provokes this both directly, by writing a narrow mask while a miss with all ways invalid is presented, and at random in a long mixed run that includes zero-mask writes. The reference model applies writes only at the clock edge, so it judges every such collision by comparing the chosen victim against the mask as it stood before the write.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // Source of the way touched by a lookup
  typedef enum logic [1:0] {
    TOUCH_NONE  = 2'd0,
    TOUCH_HIT   = 2'd1,
    TOUCH_EMPTY = 2'd2,
    TOUCH_OLD   = 2'd3
  } wpr_touch_e;

  // Next age of one way given the reference age of the touched way
  function automatic int unsigned wpr_aged(input int unsigned cur,
                                           input int unsigned refa,
                                           input bit          touched,
                                           input bit          active);
    if (!active)        return cur;
    else if (touched)   return 0;
    else if (cur < refa) return cur + 1;
    else                return cur;
  endfunction

  // Reference age used when a fill lands in an empty way
  function automatic int unsigned wpr_empty_ref(input int unsigned ways);
    return ways - 1;
  endfunction

endpackage

// File: rtl/wpr_mask_bank.sv
module wpr_mask_bank #(
  parameter int unsigned NUM_WAYS    = 12,
  parameter int unsigned NUM_CLASSES = 4,
  localparam int unsigned CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [CLS_W-1:0]                       wr_cls,
  input  logic [NUM_WAYS-1:0]                    wr_mask,
  input  logic [CLS_W-1:0]                       rd_cls,
  output logic [NUM_WAYS-1:0]                    rd_mask
);

  logic [NUM_CLASSES-1:0][NUM_WAYS-1:0] mask_q;
  logic                                 wr_accept;

  assign wr_accept = wr_en && (wr_mask != '0);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[c] <= '1;
      else if (wr_accept && (wr_cls == CLS_W'(c)))
        mask_q[c] <= wr_mask;
    end
  end

  always_comb begin
    rd_mask = mask_q[0];
    for (int c = 0; c < NUM_CLASSES; c++)
      if (rd_cls == CLS_W'(c)) rd_mask = mask_q[c];
  end

endmodule

// File: rtl/wpr_victim_pick.sv
module wpr_victim_pick #(
  parameter int unsigned NUM_WAYS = 12,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned AGE_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]       allowed,
  input  logic [NUM_WAYS-1:0]       valid,
  input  logic [NUM_WAYS*AGE_W-1:0] ages,
  output logic [WAY_W-1:0]          pick_way,
  output logic                      pick_empty
);

  logic [NUM_WAYS-1:0] empty_cand;
  logic [WAY_W-1:0]    empty_way;
  logic                empty_found;
  logic [WAY_W-1:0]    old_way;
  logic [AGE_W-1:0]    old_age;
  logic                old_seen;

  assign empty_cand = allowed & ~valid;

  // Lowest-numbered empty candidate
  always_comb begin
    empty_way   = '0;
    empty_found = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (empty_cand[w]) begin
        empty_way   = WAY_W'(w);
        empty_found = 1'b1;
      end
    end
  end

  // Oldest allowed way, strict compare keeps the lowest index on ties
  always_comb begin
    old_way  = '0;
    old_age  = '0;
    old_seen = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (allowed[w] && (!old_seen || ages[w*AGE_W +: AGE_W] > old_age)) begin
        old_way  = WAY_W'(w);
        old_age  = ages[w*AGE_W +: AGE_W];
        old_seen = 1'b1;
      end
    end
  end

  assign pick_empty = empty_found;
  assign pick_way   = empty_found ? empty_way : old_way;

endmodule

// File: rtl/wpr_recency_upd.sv
module wpr_recency_upd
  import wpr_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 12,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned AGE_W   = $clog2(NUM_WAYS)
) (
  input  logic                      active,
  input  logic [WAY_W-1:0]          touch_way,
  input  logic [AGE_W-1:0]          ref_age,
  input  logic [NUM_WAYS*AGE_W-1:0] ages_in,
  output logic [NUM_WAYS*AGE_W-1:0] ages_out
);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic [AGE_W-1:0] cur;
    logic             hit_me;
    assign cur    = ages_in[g*AGE_W +: AGE_W];
    assign hit_me = (touch_way == WAY_W'(g));
    assign ages_out[g*AGE_W +: AGE_W] =
      AGE_W'(wpr_aged(int'(cur), int'(ref_age), hit_me, active));
  end

endmodule

// File: rtl/wpr_victim_sel.sv
module wpr_victim_sel
  import wpr_pkg::*;
#(
  parameter int unsigned NUM_WAYS    = 12,
  parameter int unsigned NUM_CLASSES = 4,
  localparam int unsigned CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int unsigned WAY_W      = $clog2(NUM_WAYS),
  localparam int unsigned AGE_W      = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CLS_W-1:0]          cfg_cls,
  input  logic [NUM_WAYS-1:0]       cfg_mask,
  input  logic                      lkp_valid,
  input  logic [CLS_W-1:0]          lkp_cls,
  input  logic                      lkp_hit,
  input  logic [WAY_W-1:0]          lkp_hit_way,
  input  logic [NUM_WAYS-1:0]       set_valid,
  input  logic [NUM_WAYS*AGE_W-1:0] set_age,
  output logic                      upd_valid,
  output logic [WAY_W-1:0]          upd_way,
  output logic                      vic_valid,
  output logic [WAY_W-1:0]          vic_way,
  output logic [NUM_WAYS*AGE_W-1:0] age_next
);

  function automatic logic [AGE_W-1:0] age_at(input logic [NUM_WAYS*AGE_W-1:0] v,
                                              input logic [WAY_W-1:0] idx);
    logic [AGE_W-1:0] r;
    r = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (idx == WAY_W'(w)) r = v[w*AGE_W +: AGE_W];
    return r;
  endfunction

  logic [NUM_WAYS-1:0] cur_mask;
  logic [WAY_W-1:0]    pick_way;
  logic                pick_empty;
  wpr_touch_e          touch_src;
  logic [WAY_W-1:0]    touch_way;
  logic [AGE_W-1:0]    ref_age;
  logic                miss_ev;
  logic                hit_ev;

  wpr_mask_bank #(.NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES)) u_masks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_cls  (cfg_cls),
    .wr_mask (cfg_mask),
    .rd_cls  (lkp_cls),
    .rd_mask (cur_mask)
  );

  wpr_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .allowed    (cur_mask),
    .valid      (set_valid),
    .ages       (set_age),
    .pick_way   (pick_way),
    .pick_empty (pick_empty)
  );

  assign hit_ev  = lkp_valid &&  lkp_hit;
  assign miss_ev = lkp_valid && !lkp_hit;

  always_comb begin
    if (hit_ev)                 touch_src = TOUCH_HIT;
    else if (miss_ev && pick_empty) touch_src = TOUCH_EMPTY;
    else if (miss_ev)           touch_src = TOUCH_OLD;
    else                        touch_src = TOUCH_NONE;
  end

  always_comb begin
    unique case (touch_src)
      TOUCH_HIT: begin
        touch_way = lkp_hit_way;
        ref_age   = age_at(set_age, lkp_hit_way);
      end
      TOUCH_EMPTY: begin
        touch_way = pick_way;
        ref_age   = AGE_W'(wpr_empty_ref(NUM_WAYS));
      end
      TOUCH_OLD: begin
        touch_way = pick_way;
        ref_age   = age_at(set_age, pick_way);
      end
      default: begin
        touch_way = '0;
        ref_age   = '0;
      end
    endcase
  end

  wpr_recency_upd #(.NUM_WAYS(NUM_WAYS)) u_rec (
    .active    (touch_src != TOUCH_NONE),
    .touch_way (touch_way),
    .ref_age   (ref_age),
    .ages_in   (set_age),
    .ages_out  (age_next)
  );

  assign upd_valid = lkp_valid;
  assign upd_way   = touch_way;
  assign vic_valid = miss_ev;
  assign vic_way   = pick_way;

endmodule

// File: rtl/wpr_victim_sel_chk.sv
module wpr_victim_sel_chk #(
  parameter int unsigned NUM_WAYS    = 12,
  parameter int unsigned NUM_CLASSES = 4,
  localparam int unsigned WAY_W      = $clog2(NUM_WAYS),
  localparam int unsigned AGE_W      = $clog2(NUM_WAYS)
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  cfg_we,
  input logic [NUM_WAYS-1:0]                   cfg_mask,
  input logic                                  lkp_valid,
  input logic                                  lkp_hit,
  input logic [WAY_W-1:0]                      lkp_hit_way,
  input logic [NUM_WAYS-1:0]                   set_valid,
  input logic [NUM_WAYS-1:0]                   allowed,
  input logic [NUM_CLASSES-1:0][NUM_WAYS-1:0]  masks,
  input logic                                  upd_valid,
  input logic [WAY_W-1:0]                      upd_way,
  input logic                                  vic_valid,
  input logic [WAY_W-1:0]                      vic_way,
  input logic [NUM_WAYS*AGE_W-1:0]             age_next
);

  logic [AGE_W-1:0] touched_age;
  always_comb begin
    touched_age = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (upd_way == WAY_W'(w)) touched_age = age_next[w*AGE_W +: AGE_W];
  end

  AST_VICTIM_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> allowed[vic_way]); // R4

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && |(allowed & ~set_valid)) |-> !set_valid[vic_way]); // R5

  AST_HIT_ANY_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_hit) |-> (upd_valid && !vic_valid && upd_way == lkp_hit_way)); // R7

  AST_TOUCHED_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (touched_age == '0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (!upd_valid && !vic_valid)); // R9

  AST_ZERO_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_mask == '0) |=> $stable(masks)); // R3

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_nz
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      masks[c] != '0); // R3
  end

endmodule

bind wpr_victim_sel wpr_victim_sel_chk #(
  .NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_mask    (cfg_mask),
  .lkp_valid   (lkp_valid),
  .lkp_hit     (lkp_hit),
  .lkp_hit_way (lkp_hit_way),
  .set_valid   (set_valid),
  .allowed     (cur_mask),
  .masks       (u_masks.mask_q),
  .upd_valid   (upd_valid),
  .upd_way     (upd_way),
  .vic_valid   (vic_valid),
  .vic_way     (vic_way),
  .age_next    (age_next)
);

// File: tb/test_wpr_victim_sel.sv
module test_wpr_victim_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_cls = '0;
  logic [11:0] cfg_mask = '0;
  logic        lkp_valid = 1'b0;
  logic [1:0]  lkp_cls = '0;
  logic        lkp_hit = 1'b0;
  logic [3:0]  lkp_hit_way = '0;
  logic [11:0] set_valid = '0;
  logic [47:0] set_age = '0;
  logic        upd_valid, vic_valid;
  logic [3:0]  upd_way, vic_way;
  logic [47:0] age_next;

  int checks = 0;
  int errors = 0;
  logic [11:0] mask_m [4];

  always #5 clk = ~clk;

  wpr_victim_sel i_wpr_victim_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cls(cfg_cls), .cfg_mask(cfg_mask),
    .lkp_valid(lkp_valid), .lkp_cls(lkp_cls), .lkp_hit(lkp_hit), .lkp_hit_way(lkp_hit_way),
    .set_valid(set_valid), .set_age(set_age), .upd_valid(upd_valid), .upd_way(upd_way),
    .vic_valid(vic_valid), .vic_way(vic_way), .age_next(age_next)
  );

  function automatic int age_of(input logic [47:0] v, input int w);
    return int'(v[w*4 +: 4]);
  endfunction

  // Reference choice: search empties ascending, else find max age then first holder
  function automatic int ref_pick(input logic [11:0] allow, output bit empty);
    int top;
    empty = 0;
    for (int w = 0; w < 12; w++)
      if (allow[w] && !set_valid[w]) begin empty = 1; return w; end
    top = -1;
    for (int w = 0; w < 12; w++)
      if (allow[w] && age_of(set_age, w) > top) top = age_of(set_age, w);
    for (int w = 0; w < 12; w++)
      if (allow[w] && age_of(set_age, w) == top) return w;
    return 0;
  endfunction

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_now(input string tag);
    bit          empty;
    int          v, tw, refa;
    logic [47:0] exp_age;
    v = ref_pick(mask_m[lkp_cls], empty);
    cmp(tag, "upd_valid", int'(upd_valid), int'(lkp_valid));
    cmp(tag, "vic_valid", int'(vic_valid), int'(lkp_valid && !lkp_hit));
    exp_age = set_age;
    if (lkp_valid) begin
      if (lkp_hit) begin tw = int'(lkp_hit_way); refa = age_of(set_age, tw); end
      else begin
        tw = v;
        refa = empty ? 11 : age_of(set_age, tw);
        cmp(tag, "vic_way", int'(vic_way), v);
      end
      cmp(tag, "upd_way", int'(upd_way), tw);
      for (int w = 0; w < 12; w++) begin
        if (w == tw) exp_age[w*4 +: 4] = 4'd0;
        else if (age_of(set_age, w) < refa) exp_age[w*4 +: 4] = 4'(age_of(set_age, w) + 1);
      end
    end
    checks++;
    if (age_next !== exp_age) begin
      errors++;
      $display("FAIL %s age_next got %012h exp %012h", tag, age_next, exp_age);
    end
  endtask

  // Inputs are set at a falling edge; check, then take the rising edge
  task automatic tick(input string tag);
    #1;
    check_now(tag);
    @(posedge clk);
    if (cfg_we && cfg_mask != 12'd0) mask_m[cfg_cls] = cfg_mask;
    @(negedge clk);
    cfg_we = 0; lkp_valid = 0; lkp_hit = 0;
  endtask

  task automatic miss(input logic [1:0] cls);
    lkp_valid = 1; lkp_hit = 0; lkp_cls = cls;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) mask_m[c] = 12'hFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: each class may pick the oldest way at either end after reset
    for (int c = 0; c < 4; c++) begin
      set_valid = 12'hFFF; set_age = '0; set_age[44 +: 4] = 4'd11;
      miss(2'(c)); tick("R1");
      set_age = '0; set_age[0 +: 4] = 4'd7;
      miss(2'(c)); tick("R1");
    end

    // R3: zero write to class 0 is refused
    cfg_we = 1; cfg_cls = 0; cfg_mask = 12'h000; tick("R3");
    set_valid = 12'h000; miss(0); tick("R3");

    // R2: narrow class 0 while it misses in the same cycle
    cfg_we = 1; cfg_cls = 0; cfg_mask = 12'hF80; miss(0); tick("R2");
    miss(0); tick("R2");
    cfg_we = 1; cfg_cls = 1; cfg_mask = 12'h07F; tick("R2");

    // R4: oldest way lies outside class 1's share
    set_valid = 12'hFFF; set_age = '0; set_age[44 +: 4] = 4'd11; set_age[12 +: 4] = 4'd5;
    miss(1); tick("R4");
    miss(0); tick("R4");

    // R5: empty ways inside and outside the share
    set_valid = 12'hFFF & ~12'h604 & ~12'h004; miss(0); tick("R5");
    miss(1); tick("R5");

    // R6: equal ages then a tie between two older ways
    set_valid = 12'hFFF;
    for (int w = 0; w < 12; w++) set_age[w*4 +: 4] = 4'd4;
    miss(1); tick("R6");
    set_age[8 +: 4] = 4'd9; set_age[20 +: 4] = 4'd9; miss(1); tick("R6");

    // R7: hit outside the share of class 1
    lkp_valid = 1; lkp_hit = 1; lkp_cls = 1; lkp_hit_way = 4'd10; tick("R7");

    // R8: fill of an empty way uses the full reference age
    for (int w = 0; w < 12; w++) set_age[w*4 +: 4] = 4'(w);
    set_valid = 12'hEFF; miss(0); tick("R8");

    // R9: no lookup leaves ages alone
    set_age = 48'h0123_4567_89AB; tick("R9");

    // R3: zero write after narrowing keeps class 1 in its share
    cfg_we = 1; cfg_cls = 1; cfg_mask = 12'h000; tick("R3");
    set_valid = 12'hFFF; set_age = '0; set_age[40 +: 4] = 4'd9; miss(1); tick("R3");

    // Mixed traffic, including same-cycle writes and zero writes
    for (int n = 0; n < 4000; n++) begin
      string tg;
      bit    e;
      int    dummy;
      cfg_we   = ($urandom % 6) == 0;
      cfg_cls  = 2'($urandom);
      cfg_mask = (($urandom % 4) == 0) ? 12'h000 : 12'($urandom);
      lkp_valid = ($urandom % 4) != 0;
      lkp_hit   = ($urandom % 3) == 0;
      lkp_cls   = 2'($urandom);
      lkp_hit_way = 4'($urandom % 12);
      set_valid = ($urandom % 2) ? 12'hFFF : 12'($urandom);
      for (int w = 0; w < 12; w++) set_age[w*4 +: 4] = 4'($urandom % 12);
      dummy = ref_pick(mask_m[lkp_cls], e);
      if (!lkp_valid) tg = "R9";
      else if (lkp_hit) tg = "R7";
      else if (e) tg = "R5";
      else tg = "R6";
      tick(tg);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule